// File: doc/BRIEF.md
# Banked GPIO controller with edge-detect interrupt

The block is a memory-mapped general-purpose I/O controller holding four banks of 32 pins behind a simple 32-bit register bus. Every pin has an output value and a direction bit. The output value is changed only through write-one set and clear aliases. The direction can be written directly or through its own set and clear aliases. Each pin's input passes through a two-flop synchronizer. The synchronized value can be read back, and it feeds an edge detector.

Rising-edge and falling-edge detection is enabled per pin. Each enable can be written directly or changed bit by bit through set and clear aliases. A detected edge latches a write-one-to-clear status bit. A separate per-pin mask then decides which pending status bits reach the single interrupt output, which is shared by all banks. Software reads the status, clears it by writing back ones, and services the pins it has unmasked.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: Bank register blocks start at byte addresses 0x000, 0x004, 0x008 and 0x100 for banks 0 to 3. Register k of a bank sits at base + 12*k, for these values of k: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 status, 7 direction set, 8 direction clear, 9 rising set, 10 rising clear, 11 falling set, 12 falling clear, 13 mask. An access to one bank never changes another bank.
- R2: The level register is read-only. It returns the pin inputs after two synchronizer flops. A pin change made before clock edge n is first visible after edge n+1, and not after edge n alone.
- R3: Writing a 1 to a bit of output set drives that bit of pins_o to 1. Writing a 1 to a bit of output clear drives it to 0. Zero bits leave their pins unchanged, and both aliases read as zero.
- R4: The direction register (1 = output, shown on pins_oe_o) is read/write. Its set alias turns the selected pins into outputs and its clear alias turns them into inputs.
- R5: The rising and falling enables are read/write. Their set and clear aliases change only the bits written as 1, and writing all ones to a clear alias disables every pin of that bank.
- R6: A status bit is set by the third clock edge after its pin changes, when the change is a rise with rising detection enabled or a fall with falling detection enabled.
- R7: Writing a 1 to a status bit clears it. Zero bits leave status unchanged.
- R8: When an edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: irq_o is the OR over all banks of status AND mask, with mask 1 = enabled. A pending status bit whose mask bit is 0 does not raise irq_o.
- R10: Reads of write-only registers, unmapped addresses or non-aligned addresses return zero. Writes to unmapped addresses change nothing.
- R11: After reset all outputs, directions, enables, status and masks are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 9 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| pins_i | input | 128 | Asynchronous pin inputs, bank b at bits 32*b upward |
| pins_o | output | 128 | Output values |
| pins_oe_o | output | 128 | Direction, 1 = output |
| irq_o | output | 1 | Shared interrupt |

## Verification
The hardest case to reach is an edge landing in the same clock cycle as a clearing write to its status bit. To set it up, the stimulus changes a pin at a falling clock edge, waits exactly two rising edges through the synchronizer, and then presents the clear write so that it commits on the edge where the detector fires. Each bank is then swept with pin patterns that mix rises and falls under different enable sets. Status, level latency and interrupt gating are predicted from those patterns.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_REGS   = 14;
  localparam int REG_STRIDE = 12;
  localparam int IDX_W      = 4;

  typedef enum logic [IDX_W-1:0] {
    REG_LVL, REG_DIR, REG_OSET, REG_OCLR, REG_RISE, REG_FALL, REG_STAT,
    REG_DSET, REG_DCLR, REG_RSET, REG_RCLR, REG_FSET, REG_FCLR, REG_MASK
  } reg_idx_e;

  // first three banks interleave on word steps, later ones sit in the upper page
  function automatic int bank_base(input int b);
    return (b < 3) ? b * 4 : 32'h100 + (b - 3) * 4;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      cur_o  <= '0;
      prev_o <= '0;
    end else begin
      s1_q   <= d_i;
      cur_o  <= s1_q;
      prev_o <= cur_o;
    end
  end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec import gpio_pkg::*; #(
  parameter int NB = 4,
  parameter int AW = 9
) (
  input  logic [AW-1:0] addr_i,
  output logic [NB-1:0] hit_o,
  output reg_idx_e      idx_o
);
  always_comb begin
    hit_o = '0;
    idx_o = REG_LVL;
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (addr_i == AW'(bank_base(b) + k * REG_STRIDE)) begin
          hit_o[b] = 1'b1;
          idx_o    = reg_idx_e'(IDX_W'(k));
        end
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         we_i,
  input  reg_idx_e     idx_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o
);
  logic         wr;
  logic [W-1:0] out_d, dir_d, rise_d, fall_d, stat_d, mask_d, ev, clr;

  assign wr = sel_i & we_i;
  assign ev = (cur_i & ~prev_i & rise_o) | (~cur_i & prev_i & fall_o);
  assign clr = (wr && idx_i == REG_STAT) ? wdata_i : '0;

  always_comb begin
    out_d  = out_o;
    dir_d  = dir_o;
    rise_d = rise_o;
    fall_d = fall_o;
    mask_d = mask_o;
    if (wr) begin
      case (idx_i)
        REG_OSET: out_d  = out_o | wdata_i;
        REG_OCLR: out_d  = out_o & ~wdata_i;
        REG_DIR:  dir_d  = wdata_i;
        REG_DSET: dir_d  = dir_o | wdata_i;
        REG_DCLR: dir_d  = dir_o & ~wdata_i;
        REG_RISE: rise_d = wdata_i;
        REG_RSET: rise_d = rise_o | wdata_i;
        REG_RCLR: rise_d = rise_o & ~wdata_i;
        REG_FALL: fall_d = wdata_i;
        REG_FSET: fall_d = fall_o | wdata_i;
        REG_FCLR: fall_d = fall_o & ~wdata_i;
        REG_MASK: mask_d = wdata_i;
        default: ;
      endcase
    end
    // a new edge outranks a same-cycle clear
    stat_d = (stat_o & ~clr) | ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o  <= '0;
      dir_o  <= '0;
      rise_o <= '0;
      fall_o <= '0;
      stat_o <= '0;
      mask_o <= '0;
    end else begin
      out_o  <= out_d;
      dir_o  <= dir_d;
      rise_o <= rise_d;
      fall_o <= fall_d;
      stat_o <= stat_d;
      mask_o <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (idx_i)
        REG_LVL:  rdata_o = cur_i;
        REG_DIR:  rdata_o = dir_o;
        REG_RISE: rdata_o = rise_o;
        REG_FALL: rdata_o = fall_o;
        REG_STAT: rdata_o = stat_o;
        REG_MASK: rdata_o = mask_o;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl import gpio_pkg::*; #(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int ADDR_W        = 9
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 bus_we_i,
  input  logic [ADDR_W-1:0]                    bus_addr_i,
  input  logic [PINS_PER_BANK-1:0]             bus_wdata_i,
  output logic [PINS_PER_BANK-1:0]             bus_rdata_o,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]   pins_i,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pins_o,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pins_oe_o,
  output logic                                 irq_o
);
  localparam int W     = PINS_PER_BANK;
  localparam int NPINS = NUM_BANKS * W;

  logic [NPINS-1:0]            cur_all, prev_all, rise_all, fall_all, stat_all, mask_all;
  logic [NUM_BANKS-1:0]        bank_hit;
  reg_idx_e                    reg_idx;
  logic [NUM_BANKS-1:0][W-1:0] bank_rdata;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .cur_o (cur_all),
    .prev_o(prev_all)
  );

  gpio_addr_dec #(.NB(NUM_BANKS), .AW(ADDR_W)) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (bank_hit),
    .idx_o (reg_idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.W(W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (bank_hit[b]),
      .we_i   (bus_we_i),
      .idx_i  (reg_idx),
      .wdata_i(bus_wdata_i),
      .cur_i  (cur_all[b*W +: W]),
      .prev_i (prev_all[b*W +: W]),
      .rdata_o(bank_rdata[b]),
      .out_o  (pins_o[b*W +: W]),
      .dir_o  (pins_oe_o[b*W +: W]),
      .rise_o (rise_all[b*W +: W]),
      .fall_o (fall_all[b*W +: W]),
      .stat_o (stat_all[b*W +: W]),
      .mask_o (mask_all[b*W +: W])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) bus_rdata_o = bus_rdata_o | bank_rdata[b];
  end

  assign irq_o = |(stat_all & mask_all);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk import gpio_pkg::*; #(
  parameter int NB = 4,
  parameter int W  = 32,
  parameter int AW = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bus_we_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [W-1:0]    bus_wdata_i,
  input logic            irq_o,
  input logic [NB*W-1:0] pins_o,
  input logic [NB*W-1:0] dir_all,
  input logic [NB*W-1:0] cur_all,
  input logic [NB*W-1:0] prev_all,
  input logic [NB*W-1:0] rise_all,
  input logic [NB*W-1:0] fall_all,
  input logic [NB*W-1:0] stat_all,
  input logic [NB*W-1:0] mask_all
);
  localparam logic [AW-1:0] A_OSET0 = AW'(2 * REG_STRIDE);
  localparam logic [AW-1:0] A_STAT0 = AW'(6 * REG_STRIDE);
  localparam logic [AW-1:0] A_HOLE  = AW'('hA8);

  logic [NB*W-1:0] ev_all;
  assign ev_all = (cur_all & ~prev_all & rise_all) | (~cur_all & prev_all & fall_all);

  // R6: a status bit only appears after an enabled edge
  a_r6_status_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_all & ~$past(stat_all) & ~$past(ev_all)) == '0));

  // R8: every enabled edge leaves its bit set, clear or not
  a_r8_edge_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~stat_all & $past(ev_all)) == '0));

  // R7
  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_STAT0) |=>
      ((stat_all[W-1:0] & $past(bus_wdata_i) & ~$past(ev_all[W-1:0])) == '0));

  // R9
  a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_all & mask_all) == '0) |-> !irq_o);

  // R3
  a_r3_oset_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_OSET0) |=>
      ((pins_o[W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  // R10
  a_r10_hole_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_HOLE) |=>
      ($stable(dir_all) && $stable(mask_all) && $stable(rise_all) &&
       $stable(fall_all) && $stable(pins_o)));
endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(
  .NB(NUM_BANKS), .W(PINS_PER_BANK), .AW(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .pins_o     (pins_o),
  .dir_all    (pins_oe_o),
  .cur_all    (cur_all),
  .prev_all   (prev_all),
  .rise_all   (rise_all),
  .fall_all   (fall_all),
  .stat_all   (stat_all),
  .mask_all   (mask_all)
);

// File: tb/gpio_edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_ctrl_tb;
  localparam int NB = 4;
  localparam int W  = 32;
  localparam int LVL = 0, DIR = 1, OSET = 2, OCLR = 3, RISE = 4, FALL = 5, STAT = 6;
  localparam int DSET = 7, DCLR = 8, RSET = 9, RCLR = 10, FSET = 11, FCLR = 12, MASK = 13;

  logic            clk = 0;
  logic            rst_n;
  logic            we;
  logic [8:0]      addr;
  logic [W-1:0]    wdata, rdata;
  logic [NB*W-1:0] pin_drv, pins_o, pins_oe;
  logic            irq;
  int              total = 0, bad = 0;

  always #10 clk = ~clk;

  gpio_edge_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pins_i(pin_drv),
    .pins_o(pins_o), .pins_oe_o(pins_oe), .irq_o(irq)
  );

  function automatic logic [8:0] ra(int b, int r);
    int base = (b < 3) ? b * 4 : 256;
    return 9'(base + r * 12);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_a(logic [8:0] a, logic [W-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic wr(int b, int r, logic [W-1:0] d);
    wr_a(ra(b, r), d);
  endtask

  task automatic rd_a(logic [8:0] a, output logic [W-1:0] d);
    @(negedge clk); we = 0; addr = a; #2; d = rdata;
  endtask

  task automatic rd(int b, int r, output logic [W-1:0] d);
    rd_a(ra(b, r), d);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v, o_exp, d_exp, r_exp, f_exp, s_exp, p1, p2, re, fe, m;
    we = 0; addr = '0; wdata = '0; pin_drv = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11 reset state
    chk("R11 irq", W'(irq), '0);
    for (int b = 0; b < NB; b++) begin
      chk("R11 pins_o", pins_o[b*W +: W], '0);
      chk("R11 pins_oe", pins_oe[b*W +: W], '0);
      foreach (v[i]) if (0) v = '0;
      rd(b, DIR, v);  chk("R11 dir", v, '0);
      rd(b, RISE, v); chk("R11 rise", v, '0);
      rd(b, FALL, v); chk("R11 fall", v, '0);
      rd(b, STAT, v); chk("R11 stat", v, '0);
      rd(b, MASK, v); chk("R11 mask", v, '0);
    end

    for (int b = 0; b < NB; b++) begin
      // R3 output aliases
      o_exp = 32'hA5A5_0F0F ^ (32'h1111_1111 * b);
      wr(b, OSET, o_exp);
      chk("R3 set", pins_o[b*W +: W], o_exp);
      wr(b, OCLR, 32'h0000_FFFF << b);
      o_exp = o_exp & ~(32'h0000_FFFF << b);
      chk("R3 clr", pins_o[b*W +: W], o_exp);
      wr(b, OSET, '0);
      chk("R3 zero set", pins_o[b*W +: W], o_exp);
      rd(b, OSET, v); chk("R3 set reads 0", v, '0);
      rd(b, OCLR, v); chk("R3 clr reads 0", v, '0);

      // R4 direction
      d_exp = 32'h1234_0000 + b;
      wr(b, DIR, d_exp);
      rd(b, DIR, v); chk("R4 dir", v, d_exp);
      wr(b, DSET, 32'h0000_F0F0);
      d_exp |= 32'h0000_F0F0;
      chk("R4 dset oe", pins_oe[b*W +: W], d_exp);
      wr(b, DCLR, 32'h1200_00F0);
      d_exp &= ~32'h1200_00F0;
      rd(b, DIR, v); chk("R4 dclr", v, d_exp);
      chk("R4 dclr oe", pins_oe[b*W +: W], d_exp);
      rd(b, DSET, v); chk("R10 dset reads 0", v, '0);

      // R5 enables
      r_exp = 32'h00FF_00FF;
      wr(b, RISE, r_exp);
      wr(b, RSET, 32'hF000_0000); r_exp |= 32'hF000_0000;
      wr(b, RCLR, 32'h0000_000F); r_exp &= ~32'h0000_000F;
      rd(b, RISE, v); chk("R5 rise", v, r_exp);
      f_exp = 32'h0F0F_0000;
      wr(b, FALL, f_exp);
      wr(b, FSET, 32'h0000_0003); f_exp |= 32'h0000_0003;
      wr(b, FCLR, 32'h0F00_0000); f_exp &= ~32'h0F00_0000;
      rd(b, FALL, v); chk("R5 fall", v, f_exp);
      wr(b, RCLR, '1); wr(b, FCLR, '1);
      rd(b, RISE, v); chk("R5 rclr all", v, '0);
      rd(b, FALL, v); chk("R5 fclr all", v, '0);

      // R2 / R6 edges
      re = 32'h0F0F_00FF ^ b;
      fe = 32'hF0F0_0F0F;
      wr(b, RISE, re); wr(b, FALL, fe);
      p1 = 32'h3C3C_5A5A + 7 * b;
      @(negedge clk); pin_drv[b*W +: W] = p1;
      rd(b, LVL, v); chk("R2 level one edge", v, '0);
      rd(b, LVL, v); chk("R2 level two edges", v, p1);
      rd(b, STAT, v);
      s_exp = p1 & re;
      chk("R6 rise status", v, s_exp);
      chk("R9 masked no irq", W'(irq), '0);
      p2 = ~p1 ^ 32'h1234_5678;
      @(negedge clk); pin_drv[b*W +: W] = p2;
      repeat (3) @(posedge clk);
      s_exp |= (p2 & ~p1 & re) | (~p2 & p1 & fe);
      rd(b, STAT, v); chk("R6 mixed status", v, s_exp);
      m = s_exp & 32'h0000_FFFF;
      wr(b, MASK, m);
      chk("R9 irq on", W'(irq), W'(m != 0));
      wr(b, MASK, ~s_exp);
      chk("R9 pending masked", W'(irq), '0);
      wr(b, STAT, 32'h00FF_00FF);
      s_exp &= ~32'h00FF_00FF;
      rd(b, STAT, v); chk("R7 w1c", v, s_exp);

      // cleanup
      wr(b, RISE, '0); wr(b, FALL, '0);
      @(negedge clk); pin_drv[b*W +: W] = '0;
      repeat (3) @(posedge clk);
      wr(b, STAT, '1); wr(b, MASK, '0);
      rd(b, STAT, v); chk("R7 all clear", v, '0);
    end

    // R8 edge and clear in one cycle
    wr(2, RSET, 32'h1);
    @(negedge clk); pin_drv[2*W] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1; addr = ra(2, STAT); wdata = 32'h1;
    @(negedge clk); we = 0;
    rd(2, STAT, v); chk("R8 edge kept", v, 32'h1);
    wr(2, STAT, 32'h1);
    rd(2, STAT, v); chk("R8 later clear", v, '0);
    wr(2, RCLR, '1);

    // R1 bank isolation
    wr(3, MASK, 32'hDEAD_BEEF);
    for (int b = 0; b < 3; b++) begin
      rd(b, MASK, v); chk("R1 other mask", v, '0);
    end
    rd(3, MASK, v); chk("R1 bank3 mask", v, 32'hDEAD_BEEF);
    wr(3, MASK, '0);

    // R10 holes
    rd_a(9'h0A8, v); chk("R10 hole A8", v, '0);
    rd_a(9'h002, v); chk("R10 unaligned", v, '0);
    rd_a(9'h1A8, v); chk("R10 hole 1A8", v, '0);
    wr_a(9'h0A8, '1);
    wr_a(9'h002, '1);
    for (int b = 0; b < NB; b++) begin
      rd(b, MASK, v); chk("R10 mask kept", v, '0);
      rd(b, RISE, v); chk("R10 rise kept", v, '0);
    end
    rd(1, DIR, v); chk("R10 dir kept", v, (32'h1234_0001 | 32'h0000_F0F0) & ~32'h1200_00F0);
    chk("R10 irq", W'(irq), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule